// File: doc/BRIEF.md
# Power-management command and SMI controller

This block sits behind the power-management command port of a chipset. Each byte written to that port is decoded. Two reserved command values turn the ACPI mode bit on or off. Every other value may raise a system-management interrupt request toward the processor. An SMI is raised only when the command-enable bit in the SMI-enable register is set.

The block also holds a general power-management control word. That word carries a sticky lock bit. Once the lock bit is written to 1, it cannot be cleared by any later write, and bit 0 of the SMI-enable register (the global SMI enable) becomes write-protected. Only a reset releases the lock. Because the lock is taken directly from the stored control word, restoring that word re-applies the lock state with no further action.

Top module: `pm_cmd_smi_ctrl`

## Requirements
- R1: A command-port write of value 0x02 sets `sci_en`, and the new value is visible on the cycle after the write.
- R2: A command-port write of value 0x03 clears `sci_en`, and the new value is visible on the cycle after the write.
- R3: A command write of 0x02 or 0x03 never raises `smi_req`, whatever the SMI-enable register holds.
- R4: When bit 5 of the SMI-enable register is 1, a command write of any other value drives `smi_req` high for exactly one cycle, on the cycle after the write.
- R5: When bit 5 of the SMI-enable register is 0, a command write of any other value leaves `smi_req` low.
- R6: While bit 4 of the control word is 0, a control-word write stores all 16 bits. Once bit 4 has been stored as 1, it stays 1 through any later write until reset, and the other bits remain writable.
- R7: While the lock (control-word bit 4) is set, a write to the SMI-enable register leaves bit 0 unchanged and stores the other 31 bits.
- R8: Reset clears `sci_en`, `smi_req`, the SMI-enable register and the control word.
- R9: `sci_en` changes only on a command write of 0x02 or 0x03. Other command values, and cycles with no command write, leave it unchanged.
- R10: The lock state is taken only from the stored control word. After a reset it is released, so bit 0 of the SMI-enable register is writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_data | input | 8 | Command byte |
| smien_wr | input | 1 | SMI-enable register write strobe |
| smien_wdata | input | 32 | SMI-enable write data |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 16 | Control-word write data |
| sci_en | output | 1 | ACPI mode bit |
| smi_req | output | 1 | One-cycle SMI request pulse |
| smien_q | output | 32 | SMI-enable register readback |
| ctl_q | output | 16 | Control-word readback |

## Verification
The assertions assume that every strobe and data input holds a known value after reset. They also assume that the SMI enable bit is sampled as it stood before any SMI-enable write in the same cycle. The stimulus meets both conditions in three ways. It drives every input on the falling edge. It keeps each strobe high for exactly one cycle. It never writes the SMI-enable register in the same cycle as a command write or a lock-setting control write, so each result has a single cause.

// File: rtl/pm_cmd_smi_ctrl.sv
module pm_cmd_smi_ctrl #(
  parameter int CMD_W        = 8,
  parameter int SMIEN_W      = 32,
  parameter int CTL_W        = 16,
  parameter int ACPI_ON_CMD  = 'h02,
  parameter int ACPI_OFF_CMD = 'h03,
  parameter int APMC_BIT     = 5,
  parameter int GLB_BIT      = 0,
  parameter int LOCK_BIT     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic               smien_wr,
  input  logic [SMIEN_W-1:0] smien_wdata,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic               sci_en,
  output logic               smi_req,
  output logic [SMIEN_W-1:0] smien_q,
  output logic [CTL_W-1:0]   ctl_q
);
  localparam logic [CMD_W-1:0] ON_C  = CMD_W'(ACPI_ON_CMD);
  localparam logic [CMD_W-1:0] OFF_C = CMD_W'(ACPI_OFF_CMD);
  localparam logic [CTL_W-1:0] LOCK_M = CTL_W'(1) << LOCK_BIT;

  logic is_on, is_off, locked;
  logic [SMIEN_W-1:0] smien_d;

  assign is_on  = cmd_data == ON_C;
  assign is_off = cmd_data == OFF_C;
  assign locked = ctl_q[LOCK_BIT];

  always_comb begin
    smien_d = smien_wdata;
    if (locked) smien_d[GLB_BIT] = smien_q[GLB_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en  <= 1'b0;
      smi_req <= 1'b0;
      smien_q <= '0;
      ctl_q   <= '0;
    end else begin
      smi_req <= cmd_wr && !is_on && !is_off && smien_q[APMC_BIT];
      if (cmd_wr && is_on)  sci_en <= 1'b1;
      if (cmd_wr && is_off) sci_en <= 1'b0;
      if (smien_wr) smien_q <= smien_d;
      if (ctl_wr)   ctl_q   <= ctl_wdata | (locked ? LOCK_M : '0);
    end
  end

  p_sci_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == ON_C |=> sci_en);
  p_sci_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_data == OFF_C |=> !sci_en);
  p_no_smi_acpi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (cmd_data == ON_C || cmd_data == OFF_C) |=> !smi_req);
  p_smi_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !smi_req);
  p_smi_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smien_q[APMC_BIT] |=> !smi_req);
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[LOCK_BIT] |=> ctl_q[LOCK_BIT]);
  p_glb_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[LOCK_BIT] |=> $stable(smien_q[GLB_BIT]));
  p_sci_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(sci_en));
endmodule

// File: tb/pm_cmd_smi_ctrl_tb.sv
module pm_cmd_smi_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam logic [10:0] VEC [0:7] = '{
    {8'h02, 3'b010}, {8'h55, 3'b010}, {8'h55, 3'b111}, {8'h03, 3'b100},
    {8'h02, 3'b110}, {8'hB2, 3'b111}, {8'h00, 3'b010}, {8'hFF, 3'b111}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, smien_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] cmd_data = '0;
  logic [31:0] smien_wdata = '0;
  logic [15:0] ctl_wdata = '0;
  logic sci_en, smi_req;
  logic [31:0] smien_q;
  logic [15:0] ctl_q;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  pm_cmd_smi_ctrl dut_i (.clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .smien_wr(smien_wr), .smien_wdata(smien_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sci_en(sci_en), .smi_req(smi_req), .smien_q(smien_q), .ctl_q(ctl_q));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
    @(negedge clk); cmd_wr = 1'b0;
  endtask
  task automatic wr_smien(input logic [31:0] d);
    @(negedge clk); smien_wr = 1'b1; smien_wdata = d;
    @(negedge clk); smien_wr = 1'b0;
  endtask
  task automatic wr_ctl(input logic [15:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD*50000);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset sci_en", {31'b0, sci_en}, 0);
    chk("R8 reset smi_req", {31'b0, smi_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset smien", smien_q, 0);
    chk("R8 reset ctl", {16'b0, ctl_q}, 0);

    for (int i = 0; i < 8; i++) begin
      wr_smien({26'b0, VEC[i][2], 5'b0});
      wr_cmd(VEC[i][10:3]);
      chk($sformatf("R1/R2/R9 sci vec%0d", i), {31'b0, sci_en}, {31'b0, VEC[i][1]});
      chk($sformatf("R3/R4/R5 smi vec%0d", i), {31'b0, smi_req}, {31'b0, VEC[i][0]});
      @(negedge clk);
      chk($sformatf("R4 pulse end vec%0d", i), {31'b0, smi_req}, 0);
    end

    wr_ctl(16'h00A5);
    chk("R6 unlocked store", {16'b0, ctl_q}, 32'h00A5);
    wr_ctl(16'h0000);
    chk("R6 unlocked clear", {16'b0, ctl_q}, 0);
    wr_smien(32'h0000_0021);
    chk("R7 smien unlocked", smien_q, 32'h21);
    wr_ctl(16'h0010);
    chk("R6 lock set", {16'b0, ctl_q}, 32'h0010);
    wr_ctl(16'h8000);
    chk("R6 lock sticks", {16'b0, ctl_q}, 32'h8010);
    wr_smien(32'h0000_0040);
    chk("R7 bit0 held at 1", smien_q, 32'h41);
    wr_cmd(8'h77);
    chk("R5 smi off after bit5 cleared", {31'b0, smi_req}, 0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset ctl", {16'b0, ctl_q}, 0);
    chk("R8 reset smien", smien_q, 0);
    chk("R8 reset sci", {31'b0, sci_en}, 0);
    rst_n = 1'b1;
    wr_smien(32'h0000_0001);
    chk("R10 lock released", smien_q, 32'h1);
    wr_ctl(16'h0010);
    wr_smien(32'h0000_0000);
    chk("R7 bit0 held at 1 again", smien_q, 32'h1);
    wr_ctl(16'h0000);
    chk("R10 lock from stored word", {16'b0, ctl_q}, 32'h0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule